// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate graphics DRAM and owns the command pins from reset until the device is ready for normal traffic. After reset it holds clock-enable low for a configurable number of cycles, which stands in for the stable-power and stable-clock wait. It then raises clock-enable during a NOP cycle and issues a fixed command series. The series is a precharge of all banks, an extended mode load that turns the DLL on, a mode load with the DLL-reset bit set, a second all-bank precharge, two or more auto-refreshes, and a final mode load with the DLL-reset bit clear. Each command is followed by its own minimum spacing.

A lock timer starts at the DLL-reset mode load. The ready flag rises only after that timer has counted the lock window and the final mode load has had its spacing. While ready, the block drives NOP. A restart pulse given while ready runs the DLL-reset portion again, for example after a clock-frequency change. The rerun skips the power wait and the extended mode load, and clock-enable stays high throughout.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is asserted, cke is 0, the command pins {cs_n,ras_n,cas_n,we_n} carry NOP (4'b0111) and init_done is 0.
- R2: After reset release cke stays 0 for max(cfg_stable_cycles,1) cycles, then rises during a NOP cycle and never falls again until the next reset. Every cycle with cke 0 carries NOP.
- R3: Commands are encoded as precharge 4'b0010 with addr[8]=1 and the other address bits and ba at 0, auto-refresh 4'b0001 with ba and addr at 0, and mode load 4'b0000.
- R4: The first run issues its commands in this fixed order: precharge-all, extended mode load, DLL-reset mode load, precharge-all, refreshes, final mode load. The extended mode load has ba=1 and addr=cfg_ext_mode with bit 0 cleared. The DLL-reset mode load has ba=0 and addr=cfg_mode with bit 8 set. The final mode load has ba=0 and addr=cfg_mode with bit 8 cleared.
- R5: The first precharge comes one cycle after the cke-rise cycle. The next command follows a precharge after exactly max(cfg_trp,1) cycles, follows a mode load after max(cfg_tmrd,2) cycles, and follows a refresh after max(cfg_trfc,1) cycles. All cycles in between carry NOP.
- R6: The number of refreshes is max(cfg_nref,2).
- R7: Let the DLL-reset load issue in cycle T and let E be the cycle one mode-load spacing after the final mode load. init_done rises in cycle max(E, T+LOCK_CYCLES)+1. It then stays 1 with NOP on the pins until a restart.
- R8: A restart high in a cycle where init_done is 1 drops init_done and issues precharge-all in the next cycle. The sequence then resumes at the DLL-reset mode load with no power wait and no extended mode load, and cke stays 1. R5, R6 and R7 apply again.
- R9: A restart given while init_done is 0 has no effect on the command stream or on the cycle in which init_done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| restart | input | 1 | Re-run the DLL-reset portion; honoured only while ready |
| cfg_stable_cycles | input | CNT_W | Cycles of cke low before the first command |
| cfg_trp | input | GAP_W | Precharge-to-next-command spacing in cycles |
| cfg_tmrd | input | GAP_W | Mode-load-to-next-command spacing in cycles |
| cfg_trfc | input | GAP_W | Refresh-to-next-command spacing in cycles |
| cfg_nref | input | NREF_W | Requested number of refreshes |
| cfg_mode | input | ADDR_W | Operating mode value for the mode loads |
| cfg_ext_mode | input | ADDR_W | Value for the extended mode load |
| cke | output | 1 | Clock enable to the DRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Device ready for normal traffic |

## Verification
Outputs are decoded from registered state and become visible in the cycle that state is entered. Counting from reset release, cke therefore rises in cycle max(stable,1), the first precharge appears one cycle later, and each later command lands exactly its spacing after the one before. The bench works out the cycle number of every expected command from these rules and queues it with its encoding. A monitor samples the pins at the falling edge and compares both the cycle number and the fields of each non-NOP command against the head of that queue. The ready flag is checked one cycle before and in the cycle given by max(E, T+LOCK_CYCLES)+1. Restarts are driven right after a falling-edge sample, so they are seen at the next rising edge.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  typedef enum logic [3:0] {
    ST_STABLE,
    ST_CKE_UP,
    ST_PREA1,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PREA2,
    ST_REFRESH,
    ST_MRS_FIN,
    ST_LOCK,
    ST_DONE
  } step_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  localparam int AP_BIT     = 8;  // all-bank precharge / DLL reset bit
  localparam int DLL_EN_BIT = 0;  // extended mode: 0 enables the DLL

endpackage

// File: rtl/dinit_step_cnt.sv
module dinit_step_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (cnt != MAXV);
    cnt_d  = clr ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/dinit_lock_cnt.sv
module dinit_lock_cnt #(
  parameter int LOCK_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic lock_ok
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);

  logic [LW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          cnt_en;

  assign lock_ok = armed_q && (cnt_q >= LW'(LOCK_CYCLES));

  always_comb begin
    cnt_en  = start || (armed_q && !lock_ok);
    cnt_d   = start ? LW'(1) : cnt_q + LW'(1);
    armed_d = armed_q | start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  a_r7_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok && !start |=> lock_ok);

  a_r7_start_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !lock_ok);

endmodule

// File: rtl/dinit_cmd_enc.sv
module dinit_cmd_enc
  import dinit_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  step_e             step,
  input  logic              issue,
  input  logic [ADDR_W-1:0] mode_val,
  input  logic [ADDR_W-1:0] ext_val,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    if (issue) begin
      case (step)
        ST_PREA1, ST_PREA2: begin
          cmd          = CMD_PRE;
          addr[AP_BIT] = 1'b1;
        end
        ST_EMRS: begin
          cmd              = CMD_MRS;
          ba               = BA_W'(1);
          addr             = ext_val;
          addr[DLL_EN_BIT] = 1'b0;
        end
        ST_MRS_DLL: begin
          cmd          = CMD_MRS;
          addr         = mode_val;
          addr[AP_BIT] = 1'b1;
        end
        ST_REFRESH: begin
          cmd = CMD_REF;
        end
        ST_MRS_FIN: begin
          cmd          = CMD_MRS;
          addr         = mode_val;
          addr[AP_BIT] = 1'b0;
        end
        default: begin
          cmd = CMD_NOP;
        end
      endcase
    end
  end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dinit_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BA_W        = 2,
  parameter int CNT_W       = 16,
  parameter int GAP_W       = 8,
  parameter int NREF_W      = 4,
  parameter int LOCK_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CNT_W-1:0]  cfg_stable_cycles,
  input  logic [GAP_W-1:0]  cfg_trp,
  input  logic [GAP_W-1:0]  cfg_tmrd,
  input  logic [GAP_W-1:0]  cfg_trfc,
  input  logic [NREF_W-1:0] cfg_nref,
  input  logic [ADDR_W-1:0] cfg_mode,
  input  logic [ADDR_W-1:0] cfg_ext_mode,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);
  localparam logic [CNT_W-1:0]  TWO_C  = CNT_W'(2);
  localparam logic [NREF_W-1:0] TWO_R  = NREF_W'(2);

  step_e             step_q, step_d;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_clr;
  logic [NREF_W-1:0] ref_q, ref_d;
  logic              ref_en;
  logic              rerun_q, rerun_d, rerun_en;
  logic              cke_q, cke_d, cke_en;
  logic              lock_start, lock_ok;
  logic [CNT_W-1:0]  stable_eff, trp_eff, tmrd_eff, trfc_eff, dur;
  logic [NREF_W-1:0] nref_eff;
  logic              step_end, last_ref;
  logic [3:0]        cmd_w;

  // effective timing values with their floors
  always_comb begin
    stable_eff = (cfg_stable_cycles == '0) ? ONE_C : cfg_stable_cycles;
    trp_eff    = (cfg_trp == '0) ? ONE_C : CNT_W'(cfg_trp);
    tmrd_eff   = (CNT_W'(cfg_tmrd) < TWO_C) ? TWO_C : CNT_W'(cfg_tmrd);
    trfc_eff   = (cfg_trfc == '0) ? ONE_C : CNT_W'(cfg_trfc);
    nref_eff   = (cfg_nref < TWO_R) ? TWO_R : cfg_nref;
  end

  always_comb begin
    case (step_q)
      ST_STABLE:                      dur = stable_eff;
      ST_PREA1, ST_PREA2:             dur = trp_eff;
      ST_EMRS, ST_MRS_DLL, ST_MRS_FIN: dur = tmrd_eff;
      ST_REFRESH:                     dur = trfc_eff;
      default:                        dur = ONE_C;
    endcase
    step_end = (cnt == dur - ONE_C);
    last_ref = (ref_q == nref_eff - NREF_W'(1));
  end

  // next-state logic
  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_STABLE:  if (step_end) step_d = ST_CKE_UP;
      ST_CKE_UP:  step_d = ST_PREA1;
      ST_PREA1:   if (step_end) step_d = rerun_q ? ST_MRS_DLL : ST_EMRS;
      ST_EMRS:    if (step_end) step_d = ST_MRS_DLL;
      ST_MRS_DLL: if (step_end) step_d = ST_PREA2;
      ST_PREA2:   if (step_end) step_d = ST_REFRESH;
      ST_REFRESH: if (step_end && last_ref) step_d = ST_MRS_FIN;
      ST_MRS_FIN: if (step_end) step_d = ST_LOCK;
      ST_LOCK:    if (lock_ok) step_d = ST_DONE;
      ST_DONE:    if (restart) step_d = ST_PREA1;
      default:    step_d = ST_STABLE;
    endcase
  end

  always_comb begin
    cnt_clr    = (step_d != step_q) || (step_q == ST_REFRESH && step_end);
    ref_en     = (step_d == ST_REFRESH);
    ref_d      = (step_q != ST_REFRESH) ? '0 :
                 (step_end ? ref_q + NREF_W'(1) : ref_q);
    rerun_en   = (step_q == ST_DONE) && restart;
    rerun_d    = 1'b1;
    cke_en     = (step_d == ST_CKE_UP);
    cke_d      = 1'b1;
    lock_start = (step_q == ST_MRS_DLL) && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= ST_STABLE;
      ref_q   <= '0;
      rerun_q <= 1'b0;
      cke_q   <= 1'b0;
    end else begin
      step_q <= step_d;
      if (ref_en)   ref_q   <= ref_d;
      if (rerun_en) rerun_q <= rerun_d;
      if (cke_en)   cke_q   <= cke_d;
    end
  end

  dinit_step_cnt #(.W(CNT_W)) u_step_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cnt   (cnt)
  );

  dinit_lock_cnt #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (lock_start),
    .lock_ok (lock_ok)
  );

  dinit_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_cmd_enc (
    .step     (step_q),
    .issue    (cnt == '0),
    .mode_val (cfg_mode),
    .ext_val  (cfg_ext_mode),
    .cmd      (cmd_w),
    .ba       (ba),
    .addr     (addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd_w;
  assign cke       = cke_q;
  assign init_done = (step_q == ST_DONE);

  a_r2_nop_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd_w == CMD_NOP));

  a_r2_cke_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  a_r3_prea_sets_ap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == CMD_PRE) |-> addr[AP_BIT]);

  a_r7_done_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> lock_ok);

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    init_done && !restart |=> init_done && (cmd_w == CMD_NOP));

  a_r8_restart_precharges: assert property (@(posedge clk) disable iff (!rst_n)
    init_done && restart |=> !init_done && (cmd_w == CMD_PRE) && cke);

endmodule

// File: tb/dram_init_seq_tb.sv
module dram_init_seq_tb;

  localparam int LOCK = 200;

  typedef struct {
    int         slot;
    logic [3:0] cmd;
    logic [1:0] ba;
    logic [11:0] addr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        restart;
  logic [15:0] cfg_stable_cycles;
  logic [7:0]  cfg_trp, cfg_tmrd, cfg_trfc;
  logic [3:0]  cfg_nref;
  logic [11:0] cfg_mode, cfg_ext_mode;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [11:0] addr;

  int   checks = 0;
  int   fails  = 0;
  int   cyc;
  exp_t q[$];

  always #5 clk = ~clk;

  dram_init_seq #(.LOCK_CYCLES(LOCK)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .cfg_stable_cycles(cfg_stable_cycles), .cfg_trp(cfg_trp),
    .cfg_tmrd(cfg_tmrd), .cfg_trfc(cfg_trfc), .cfg_nref(cfg_nref),
    .cfg_mode(cfg_mode), .cfg_ext_mode(cfg_ext_mode),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic push(input int s, input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
    exp_t e;
    e.slot = s; e.cmd = c; e.ba = b; e.addr = a;
    q.push_back(e);
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // driver side of the scoreboard: expected schedule from the requirements
  task automatic plan(input int start, input bit rerun, input int n, input int trp,
                      input int tmrd, input int trfc, input int nref,
                      input logic [11:0] mode, input logic [11:0] ext, output int done);
    int t, tdll, rp, mrd, rfc;
    rp = mx(trp, 1); mrd = mx(tmrd, 2); rfc = mx(trfc, 1);
    t = rerun ? start : mx(n, 1) + 1;
    push(t, 4'b0010, 2'd0, 12'h100); t += rp;
    if (!rerun) begin
      push(t, 4'b0000, 2'd1, ext & 12'hFFE); t += mrd;
    end
    tdll = t;
    push(t, 4'b0000, 2'd0, mode | 12'h100); t += mrd;
    push(t, 4'b0010, 2'd0, 12'h100); t += rp;
    for (int i = 0; i < mx(nref, 2); i++) begin
      push(t, 4'b0001, 2'd0, 12'h000); t += rfc;
    end
    push(t, 4'b0000, 2'd0, mode & 12'hEFF); t += mrd;
    done = mx(t, tdll + LOCK) + 1;
  endtask

  // monitor: pop and compare each non-NOP command
  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      c = {cs_n, ras_n, cas_n, we_n};
      if (!cke) check(c == 4'b0111, "R2 nop while cke low", c, 4'b0111);
      if (c != 4'b0111) begin
        if (q.size() == 0) begin
          check(1'b0, "R4 unexpected command", c, 4'b0111);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.slot, "R5 command cycle", cyc, e.slot);
          check(c == e.cmd, "R4 command order", c, e.cmd);
          check(ba == e.ba && addr == e.addr, "R3 bank/address",
                {ba, addr}, {e.ba, e.addr});
        end
      end
    end
  end

  task automatic wait_slot(input int s);
    while (cyc < s) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cke == 1'b0 && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && !init_done,
          "R1 reset state", {cke, cs_n, ras_n, cas_n, we_n, init_done}, 6'b001110);
    #1 rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int done_a, done_b, done_r, rs;
    rst_n = 1'b0; restart = 1'b0;
    // run A: nref below floor, mode with bit 8 set, ext with bit 0 set
    cfg_stable_cycles = 16'd10; cfg_trp = 8'd4; cfg_tmrd = 8'd2; cfg_trfc = 8'd15;
    cfg_nref = 4'd0; cfg_mode = 12'h133; cfg_ext_mode = 12'h043;
    do_reset();
    plan(0, 1'b0, 10, 4, 2, 15, 0, 12'h133, 12'h043, done_a);
    wait_slot(9);
    check(cke == 1'b0, "R2 cke low before stable end", cke, 0);
    wait_slot(10);
    check(cke == 1'b1 && {cs_n, ras_n, cas_n, we_n} == 4'b0111,
          "R2 cke rises on nop", {cke, cs_n, ras_n, cas_n, we_n}, 5'b10111);
    // R9: restart mid-sequence is ignored
    wait_slot(30); restart = 1'b1;
    wait_slot(31); restart = 1'b0;
    wait_slot(done_a - 1);
    check(!init_done, "R7 done not early", init_done, 0);
    wait_slot(done_a);
    check(init_done, "R7 done rises", init_done, 1);
    check(q.size() == 0, "R6 all commands seen", q.size(), 0);
    // R8: restart from ready
    rs = done_a + 7;
    wait_slot(rs);
    plan(rs + 1, 1'b1, 0, 4, 2, 15, 0, 12'h133, 12'h043, done_r);
    restart = 1'b1;
    wait_slot(rs + 1); restart = 1'b0;
    check(!init_done && cke, "R8 done drops, cke held", {init_done, cke}, 2'b01);
    wait_slot(done_r - 1);
    check(!init_done, "R8 rerun done not early", init_done, 0);
    wait_slot(done_r);
    check(init_done, "R8 rerun done rises", init_done, 1);
    check(q.size() == 0, "R8 rerun commands seen", q.size(), 0);
    wait_slot(done_r + 5);
    check(init_done && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R7 ready holds nop",
          {init_done, cs_n, ras_n, cas_n, we_n}, 5'b10111);

    // run B: floors on trp/tmrd, long refresh, three refreshes
    cfg_stable_cycles = 16'd5; cfg_trp = 8'd1; cfg_tmrd = 8'd0; cfg_trfc = 8'd120;
    cfg_nref = 4'd3; cfg_mode = 12'h021; cfg_ext_mode = 12'h000;
    do_reset();
    plan(0, 1'b0, 5, 1, 0, 120, 3, 12'h021, 12'h000, done_b);
    wait_slot(done_b - 1);
    check(!init_done, "R7 done waits for sequence", init_done, 0);
    wait_slot(done_b);
    check(init_done, "R7 done after final spacing", init_done, 1);
    check(q.size() == 0, "R6 three refreshes seen", q.size(), 0);
    summary();
  end

endmodule